// File: doc/BRIEF.md
# NAND Page Hardware ECC Generator

This block watches the byte stream on a NAND flash data path and builds a Hamming-style check code as the bytes go by. For each run of 256 data bytes it builds a 3-byte code: 16 line-parity bits taken from the byte's position in the chunk, and 6 column-parity bits taken from bit positions within the bytes. A 512-byte page therefore yields 6 code bytes, held in two slots. All parity bits are stored inverted, so an erased page (all 0xFF) produces an all-ones code.

A 2-bit mode field controls the block. One value clears it, one lets it accumulate, one freezes it, and one switches the data-register read path over to the stored code. In read-out mode each read of the data register returns the next code byte. Software compares these bytes with the code stored in the spare area and corrects any error itself.

Top module: `nand_ecc_gen`

## Requirements
- R1: The mode field `ecc_mode_i` is decoded as 2'b11 = clear, 2'b01 = accumulate, 2'b10 = read-out and 2'b00 = off. `code_sel_o` is high exactly while the mode is read-out.
- R2: Clear mode, and also `rst_n` low, zero the parity accumulators, the byte position and the chunk count, and set every stored code byte to 0xFF. After a clear, a read-out with no data accumulated returns six 0xFF bytes, and a page of all-0xFF data also yields six 0xFF bytes.
- R3: In accumulate mode every counted byte updates the parity. Code byte 0 bit 2k+b is the inverted parity of all bytes whose chunk index bit k equals b, for k = 0..3 and b = 0..1. Code byte 1 bit 2k+b uses index bits k = 4..7 in the same way, at bit 2(k-4)+b.
- R4: Code byte 2 bits 7:2 hold the inverted column parities. Bit 2+2m+b is the parity of all data bits whose bit position has bit m equal to b, for m = 0..2 and b = 0..1. Bits 1:0 of code byte 2 are always 1.
- R5: A transfer with `cle_i` or `ale_i` high is not counted and leaves the code unchanged.
- R6: The first 256 counted bytes after a clear produce the code in slot 0, and the next 256 produce the code in slot 1. Bytes after the 512th are ignored until the next clear.
- R7: Entering read-out mode resets the read pointer. Each `code_rd_i` pulse in read-out mode advances it. For each slot in turn the order is code byte 1, code byte 0, code byte 2, and the pointer wraps to the first byte after the sixth.
- R8: In off and read-out modes, transfers are ignored and the accumulated state is held. When accumulate mode resumes without a clear, counting continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_mode_i | input | 2 | ECC mode field from the mode control register |
| xfer_i | input | 1 | One byte moves across the flash data path this cycle |
| cle_i | input | 1 | Command latch phase is active |
| ale_i | input | 1 | Address latch phase is active |
| data_i | input | 8 | Byte on the flash data path |
| code_rd_i | input | 1 | Data register read strobe |
| code_sel_o | output | 1 | Data register read path returns code bytes |
| code_o | output | 8 | Code byte selected by the read pointer |

## Verification
The bench mixes random pages, with command and address bytes interleaved, against an erased page. A design that counted control-phase bytes, or that got a line- or column-parity mapping wrong, would return code bytes that do not match a per-bit reference model. A page is stopped midway, and junk bytes are sent in off and read-out modes before accumulation resumes: a design that does not hold its state, or that restarts the byte count, gives a different code than an uninterrupted page. The bench also sends a 600-byte stream and a half page. These expose a design that writes past slot 1, or that latches a slot at the wrong byte. Read-out is re-entered after partial reads and read past the sixth byte, to catch a pointer that fails to reset or to wrap.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    ECC_OFF = 2'b00,
    ECC_ACC = 2'b01,
    ECC_OUT = 2'b10,
    ECC_CLR = 2'b11
  } ecc_mode_e;

  localparam int CHUNK_BYTES = 256;
  localparam int IDX_W       = $clog2(CHUNK_BYTES);
  localparam int LP_W        = 2 * IDX_W;
  localparam int CODE_BYTES  = 3;
  localparam int CODE_W      = 8 * CODE_BYTES;

  // Fold one byte into the line-parity vector: its parity toggles one of
  // each pair of bits, chosen by the matching bit of the byte index.
  function automatic logic [LP_W-1:0] lp_update(input logic [LP_W-1:0] lp,
                                                input logic [IDX_W-1:0] idx,
                                                input logic [7:0] d);
    logic [LP_W-1:0] r;
    logic p;
    r = lp;
    p = ^d;
    for (int k = 0; k < IDX_W; k++) begin
      if (p) r[2*k + int'(idx[k])] = ~r[2*k + int'(idx[k])];
    end
    return r;
  endfunction

  // Turn the line parities and the XOR of all bytes into the inverted code.
  function automatic logic [CODE_W-1:0] pack_code(input logic [LP_W-1:0] lp,
                                                  input logic [7:0] col);
    logic [5:0] cp;
    cp[0] = col[0] ^ col[2] ^ col[4] ^ col[6];
    cp[1] = col[1] ^ col[3] ^ col[5] ^ col[7];
    cp[2] = col[0] ^ col[1] ^ col[4] ^ col[5];
    cp[3] = col[2] ^ col[3] ^ col[6] ^ col[7];
    cp[4] = ^col[3:0];
    cp[5] = ^col[7:4];
    return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
  endfunction

  // Read-out order within a group: byte 1, byte 0, byte 2.
  function automatic logic [7:0] pick_byte(input logic [CODE_W-1:0] code,
                                           input logic [1:0] pos);
    case (pos)
      2'd0:    return code[15:8];
      2'd1:    return code[7:0];
      default: return code[23:16];
    endcase
  endfunction

endpackage

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
  import nand_ecc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  output logic       clr_o,
  output logic       acc_en_o,
  output logic       out_sel_o,
  output logic       out_entry_o
);
  ecc_mode_e mode_now;
  ecc_mode_e mode_q;

  assign mode_now = ecc_mode_e'(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= ECC_OFF;
    else        mode_q <= mode_now;
  end

  assign clr_o       = (mode_now == ECC_CLR);
  assign acc_en_o    = (mode_now == ECC_ACC);
  assign out_sel_o   = (mode_now == ECC_OUT);
  assign out_entry_o = out_sel_o && (mode_q != ECC_OUT);
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2,
  localparam int CNT_W = $clog2(NUM_CHUNKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              acc_en_i,
  input  logic              xfer_i,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic [7:0]        data_i,
  output logic              take_o,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  slot_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [LP_W-1:0]  lp_q, lp_nx;
  logic [7:0]       col_q, col_nx;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full   = (cnt_q == CNT_W'(NUM_CHUNKS));
  assign take_o = acc_en_i && xfer_i && !cle_i && !ale_i && !full;
  assign lp_nx  = lp_update(lp_q, idx_q, data_i);
  assign col_nx = col_q ^ data_i;
  assign done_o = take_o && (idx_q == {IDX_W{1'b1}});
  assign code_o = pack_code(lp_nx, col_nx);
  assign slot_o = cnt_q;
  assign idx_o  = idx_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q  <= '0;
      col_q <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      lp_q  <= '0;
      col_q <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (take_o) begin
      idx_q <= idx_q + 1'b1;
      if (done_o) begin
        lp_q  <= '0;
        col_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        lp_q  <= lp_nx;
        col_q <= col_nx;
      end
    end
  end
endmodule

// File: rtl/ecc_code_store.sv
module ecc_code_store
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2,
  localparam int CNT_W = $clog2(NUM_CHUNKS + 1),
  localparam int TOTAL = NUM_CHUNKS * CODE_BYTES,
  localparam int PTR_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [CNT_W-1:0]  wr_slot_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              out_sel_i,
  input  logic              out_entry_i,
  input  logic              rd_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [7:0]        byte_o
);
  logic [CODE_W-1:0] slot_w [NUM_CHUNKS];
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  grp;
  logic [PTR_W-1:0]  pos;
  logic [CODE_W-1:0] sel_code;

  for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_slot
    logic [CODE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '1;
      else if (clr_i)                              q <= '1;
      else if (wr_i && wr_slot_i == CNT_W'(i))     q <= wr_code_i;
    end
    assign slot_w[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ptr_q <= '0;
    else if (clr_i)              ptr_q <= '0;
    else if (out_entry_i)        ptr_q <= '0;
    else if (out_sel_i && rd_i)  ptr_q <= (ptr_q == PTR_W'(TOTAL - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign grp = ptr_q / PTR_W'(CODE_BYTES);
  assign pos = ptr_q % PTR_W'(CODE_BYTES);

  always_comb begin
    sel_code = '1;
    for (int i = 0; i < NUM_CHUNKS; i++) begin
      if (grp == PTR_W'(i)) sel_code = slot_w[i];
    end
  end

  assign ptr_o  = ptr_q;
  assign byte_o = pick_byte(sel_code, pos[1:0]);
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ecc_mode_i,
  input  logic       xfer_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic [7:0] data_i,
  input  logic       code_rd_i,
  output logic       code_sel_o,
  output logic [7:0] code_o
);
  localparam int CNT_W = $clog2(NUM_CHUNKS + 1);
  localparam int PTR_W = $clog2(NUM_CHUNKS * CODE_BYTES);

  // Named internal events, observed by the bound checker.
  logic              clr_ev;
  logic              acc_en;
  logic              out_entry;
  logic              byte_take;
  logic              chunk_done;
  logic [CODE_W-1:0] chunk_code;
  logic [CNT_W-1:0]  chunk_slot;
  logic [IDX_W-1:0]  byte_idx;
  logic [CNT_W-1:0]  chunk_cnt;
  logic [PTR_W-1:0]  rd_ptr;

  ecc_mode_ctrl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (ecc_mode_i),
    .clr_o       (clr_ev),
    .acc_en_o    (acc_en),
    .out_sel_o   (code_sel_o),
    .out_entry_o (out_entry)
  );

  ecc_accum #(.NUM_CHUNKS(NUM_CHUNKS)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_ev),
    .acc_en_i (acc_en),
    .xfer_i   (xfer_i),
    .cle_i    (cle_i),
    .ale_i    (ale_i),
    .data_i   (data_i),
    .take_o   (byte_take),
    .done_o   (chunk_done),
    .code_o   (chunk_code),
    .slot_o   (chunk_slot),
    .idx_o    (byte_idx),
    .cnt_o    (chunk_cnt)
  );

  ecc_code_store #(.NUM_CHUNKS(NUM_CHUNKS)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_ev),
    .wr_i        (chunk_done),
    .wr_slot_i   (chunk_slot),
    .wr_code_i   (chunk_code),
    .out_sel_i   (code_sel_o),
    .out_entry_i (out_entry),
    .rd_i        (code_rd_i),
    .ptr_o       (rd_ptr),
    .byte_o      (code_o)
  );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int NUM_CHUNKS = 2,
  localparam int CNT_W = $clog2(NUM_CHUNKS + 1),
  localparam int PTR_W = $clog2(NUM_CHUNKS * 3)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       ecc_mode_i,
  input logic             xfer_i,
  input logic             cle_i,
  input logic             ale_i,
  input logic             code_rd_i,
  input logic             out_entry,
  input logic [7:0]       byte_idx,
  input logic [CNT_W-1:0] chunk_cnt,
  input logic [PTR_W-1:0] rd_ptr
);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_cnt <= CNT_W'(NUM_CHUNKS));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_mode_i == 2'b11 |=> (byte_idx == 8'd0 && chunk_cnt == '0));

  assert_ctrl_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_mode_i != 2'b11 && xfer_i && (cle_i || ale_i))
      |=> ($stable(byte_idx) && $stable(chunk_cnt)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_mode_i == 2'b00 || ecc_mode_i == 2'b10)
      |=> ($stable(byte_idx) && $stable(chunk_cnt)));

  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_mode_i == 2'b01 && xfer_i && !cle_i && !ale_i &&
     chunk_cnt < CNT_W'(NUM_CHUNKS) && byte_idx != 8'hFF)
      |=> (byte_idx == $past(byte_idx) + 8'd1));

  assert_ptr_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_entry |=> rd_ptr == '0);

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_mode_i == 2'b10 && !out_entry && !code_rd_i) |=> $stable(rd_ptr));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.NUM_CHUNKS(NUM_CHUNKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ecc_mode_i (ecc_mode_i),
  .xfer_i     (xfer_i),
  .cle_i      (cle_i),
  .ale_i      (ale_i),
  .code_rd_i  (code_rd_i),
  .out_entry  (out_entry),
  .byte_idx   (byte_idx),
  .chunk_cnt  (chunk_cnt),
  .rd_ptr     (rd_ptr)
);

// File: tb/nand_ecc_gen_test.sv
module nand_ecc_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ecc_mode_i = 2'b00;
  logic       xfer_i = 1'b0;
  logic       cle_i = 1'b0;
  logic       ale_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       code_rd_i = 1'b0;
  logic       code_sel_o;
  logic [7:0] code_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 0;
  logic [7:0] pg [0:599];
  logic [7:0] ex [0:5];

  always #2 clk = ~clk;

  nand_ecc_gen uut (
    .clk(clk), .rst_n(rst_n), .ecc_mode_i(ecc_mode_i), .xfer_i(xfer_i),
    .cle_i(cle_i), .ale_i(ale_i), .data_i(data_i), .code_rd_i(code_rd_i),
    .code_sel_o(code_sel_o), .code_o(code_o)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // Per-bit reference: every set data bit toggles its line and column parities.
  function automatic logic [23:0] ref_code(input int base);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int b = 0; b < 256; b++)
      for (int j = 0; j < 8; j++)
        if (pg[base + b][j]) begin
          for (int k = 0; k < 8; k++) lp[2*k + ((b >> k) & 1)] ^= 1'b1;
          for (int k = 0; k < 3; k++) cp[2*k + ((j >> k) & 1)] ^= 1'b1;
        end
    return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
  endfunction

  task automatic build_exp(input int nslots);
    for (int g = 0; g < 2; g++) begin
      logic [23:0] c;
      c = (g < nslots) ? ref_code(256 * g) : 24'hFFFFFF;
      ex[3*g]     = c[15:8];
      ex[3*g + 1] = c[7:0];
      ex[3*g + 2] = c[23:16];
    end
  endtask

  task automatic start_page();
    @(negedge clk); ecc_mode_i = 2'b11; xfer_i = 0;
    @(negedge clk); ecc_mode_i = 2'b00;
    @(negedge clk); ecc_mode_i = 2'b01;
  endtask

  task automatic send(input logic [7:0] d, input logic c, input logic a);
    @(negedge clk); xfer_i = 1; data_i = d; cle_i = c; ale_i = a;
  endtask

  task automatic idle();
    @(negedge clk); xfer_i = 0; cle_i = 0; ale_i = 0;
  endtask

  task automatic read_codes(input string tag);
    @(negedge clk); ecc_mode_i = 2'b00; xfer_i = 0; code_rd_i = 0;
    chk({7'd0, code_sel_o}, 8'd0, "R1 sel low in off");
    @(negedge clk); ecc_mode_i = 2'b10;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk({7'd0, code_sel_o}, 8'd1, "R1 sel high in read-out");
      chk(code_o, ex[i], $sformatf("%s byte %0d", tag, i));
      code_rd_i = 1;
    end
    @(negedge clk);
    chk(code_o, ex[0], "R7 pointer wrap");
    code_rd_i = 0; ecc_mode_i = 2'b00;
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    chk({7'd0, code_sel_o}, 8'd0, "R2 reset sel");
    rst_n = 1;
    // Reset state: all slots erased
    build_exp(0);
    read_codes("R2 reset code");

    // Random page with interleaved command/address bytes
    for (int i = 0; i < 600; i++) pg[i] = 8'($urandom);
    start_page();
    for (int i = 0; i < 512; i++) begin
      if ($urandom % 8 == 0) begin
        if ($urandom % 2 == 0) send(8'($urandom), 1'b1, 1'b0);
        else                   send(8'($urandom), 1'b0, 1'b1);
      end
      send(pg[i], 1'b0, 1'b0);
    end
    idle();
    build_exp(2);
    read_codes("R3 R4 R5 R6 random page");

    // Re-enter read-out after partial reads: pointer restarts (R7)
    @(negedge clk); ecc_mode_i = 2'b10;
    @(negedge clk); code_rd_i = 1;
    @(negedge clk); code_rd_i = 1;
    @(negedge clk); code_rd_i = 0; ecc_mode_i = 2'b00;
    @(negedge clk); ecc_mode_i = 2'b10;
    @(negedge clk); chk(code_o, ex[0], "R7 re-entry resets pointer");
    ecc_mode_i = 2'b00;

    // Erased page
    for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
    start_page();
    for (int i = 0; i < 512; i++) send(pg[i], 1'b0, 1'b0);
    idle();
    build_exp(2);
    read_codes("R2 erased page");

    // Interrupted page: off and read-out in the middle, junk ignored (R8)
    for (int i = 0; i < 512; i++) pg[i] = 8'($urandom);
    start_page();
    for (int i = 0; i < 100; i++) send(pg[i], 1'b0, 1'b0);
    @(negedge clk); ecc_mode_i = 2'b00; xfer_i = 0;
    for (int i = 0; i < 20; i++) send(8'($urandom), 1'b0, 1'b0);
    idle();
    build_exp(0);
    read_codes("R8 mid-page not latched");
    @(negedge clk); ecc_mode_i = 2'b10;
    for (int i = 0; i < 10; i++) send(8'($urandom), 1'b0, 1'b0);
    idle();
    @(negedge clk); ecc_mode_i = 2'b00;
    @(negedge clk); ecc_mode_i = 2'b01;
    for (int i = 100; i < 512; i++) send(pg[i], 1'b0, 1'b0);
    idle();
    build_exp(2);
    read_codes("R8 resumed page");

    // Overflow: bytes beyond 512 ignored (R6)
    for (int i = 0; i < 600; i++) pg[i] = 8'($urandom);
    start_page();
    for (int i = 0; i < 600; i++) send(pg[i], 1'b0, 1'b0);
    idle();
    build_exp(2);
    read_codes("R6 overflow");

    // Half page: only slot 0 latched (R6)
    for (int i = 0; i < 256; i++) pg[i] = 8'($urandom);
    start_page();
    for (int i = 0; i < 256; i++) send(pg[i], 1'b0, 1'b0);
    idle();
    build_exp(1);
    read_codes("R6 half page");

    // Directed single-byte patterns in chunk 0 exercise single parity bits
    for (int i = 0; i < 256; i++) pg[i] = 8'h00;
    pg[8'hA5] = 8'h20;
    start_page();
    for (int i = 0; i < 256; i++) send(pg[i], 1'b0, 1'b0);
    idle();
    build_exp(1);
    read_codes("R3 R4 single bit");

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule